// File: doc/BRIEF.md
# Interrupt Destination Bitmask Decoder

This block turns one interrupt delivery request into the set of processors that should receive it. A request carries a 32-bit destination field, a physical/logical addressing flag, a two-bit shorthand code, the index of the sending processor and a flag that asks for lowest-priority delivery. Each of the N target controllers describes itself through per-target configuration inputs: a presence flag, an extended-addressing flag, a 32-bit physical ID, an 8-bit legacy logical ID with a flat/cluster model select, and a 32-bit extended logical ID.

The per-target matching, the shorthand override and the presence filter are combinational. The result is captured in one register stage together with the lowest-indexed selected target, so a request presented with `req_valid` in cycle t appears on the outputs in cycle t+1 with `out_valid` high. The number of target slots is the parameter rounded up to a multiple of 32; slots past the parameter are never selected. Injection of the interrupt and arbitration between targets belong to other blocks.

Top module: `irq_dest_decoder`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `req_valid` high; outputs change only on such a cycle and otherwise hold their values.
- R2: Shorthand code 0 uses the destination field; code 1 selects only the slot `req_self`; code 2 selects every slot; code 3 selects every slot except `req_self`.
- R3: With shorthand 0, physical addressing (`req_logical`=0) and destination 0xFFFFFFFF, every target is selected.
- R4: With shorthand 0 and physical addressing, an extended-mode target is selected when its full 32-bit physical ID equals the destination; a legacy target is selected when bits 7:0 of its physical ID equal destination bits 7:0; a destination of exactly 0x000000FF additionally selects every legacy target.
- R5: With shorthand 0, logical addressing and destination 0xFFFFFFFF, every extended-mode target is selected and legacy targets follow their normal logical rule on destination bits 7:0.
- R6: With logical addressing, an extended-mode target is selected when destination bits 31:16 equal its extended logical ID bits 31:16 and destination bits 15:0 share a set bit with ID bits 15:0.
- R7: With logical addressing, a legacy target whose model select is 0 (flat) is selected when destination bits 7:0 share a set bit with its 8-bit logical ID.
- R8: With logical addressing, a legacy target whose model select is 1 (cluster) is selected when destination bits 7:4 equal its ID bits 7:4 or equal 0xF, and destination bits 3:0 share a set bit with its ID bits 3:0.
- R9: A slot whose presence flag is 0, and every slot at index NUM_TGT or above, is never set in `out_mask`.
- R10: `out_pick_idx` is the lowest set index of the selected set and `out_pick_valid` is 1; when the set is empty `out_pick_valid` is 0 and `out_pick_idx` is 0.
- R11: With `req_lowpri`=1, `out_mask` carries only the bit at the picked index, or is all zero when the set is empty.
- R12: After reset `out_valid`, `out_mask`, `out_pick_valid` and `out_pick_idx` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_dest | input | 32 | Destination field |
| req_logical | input | 1 | 0 physical, 1 logical addressing |
| req_shorthand | input | 2 | 0 field, 1 self, 2 all, 3 all but self |
| req_lowpri | input | 1 | Reduce the set to one target |
| req_self | input | $clog2(NUM_SLOTS) | Slot index of the sender |
| tgt_present | input | NUM_TGT | Slot holds a controller |
| tgt_ext | input | NUM_TGT | Target uses extended addressing |
| tgt_phys_id | input | 32*NUM_TGT | Physical ID per target, slot i at bits 32i+31:32i |
| tgt_log8 | input | 8*NUM_TGT | Legacy logical ID per target |
| tgt_cluster | input | NUM_TGT | Legacy model select, 1 cluster |
| tgt_log32 | input | 32*NUM_TGT | Extended logical ID per target |
| out_valid | output | 1 | Result valid |
| out_mask | output | NUM_SLOTS | Selected targets |
| out_pick_valid | output | 1 | Selected set non-empty |
| out_pick_idx | output | $clog2(NUM_SLOTS) | Lowest selected slot |

## Verification
The bench aims at the broadcast corners: an all-ones destination behaves differently in physical and logical addressing, and a decoder that treated both alike would wrongly select legacy targets with no matching logical bits. Destination 0xFF against 0x1FF separates a true legacy broadcast from a low-byte compare, and a design that masked the destination to eight bits first would broadcast on both. The cluster value 0xF, an absent sender under shorthand 3, the slots beyond the parameter, and lowest-priority reduction of an empty set are each driven, where an error would show up as a stray bit in the mask or a pick that claims a target.

// File: rtl/irqd_pkg.sv
// Package: shared constants and types for the destination decoder.
// Assumes destination fields are 32 bits wide.
package irqd_pkg;

    typedef enum logic [1:0] {
        SH_FIELD  = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    localparam logic [31:0] DEST_ALL_ONES = 32'hFFFF_FFFF;
    localparam logic [31:0] LEGACY_BCAST  = 32'h0000_00FF;
    localparam logic [3:0]  CLUSTER_ANY   = 4'hF;

    // Round a target count up to a whole number of 32-slot words.
    function automatic int round_to_word(input int n);
        return ((n + 31) / 32) * 32;
    endfunction

endpackage

// File: rtl/irqd_lane.sv
// Module: irqd_lane
// Decides whether one target accepts a destination field, using the
// target's own addressing mode and IDs. Purely combinational; the
// shorthand override and presence filter are applied elsewhere.
module irqd_lane
    import irqd_pkg::*;
(
    input  logic [31:0] dest,
    input  logic        logical,
    input  logic        ext,
    input  logic        cluster_model,
    input  logic [31:0] phys_id,
    input  logic [7:0]  log8,
    input  logic [31:0] log32,
    output logic        hit
);

    logic all_ones;
    logic phys_hit;
    logic ext_log_hit;
    logic flat_hit;
    logic clus_hit;

    // Evaluate each addressing rule for this target.
    always_comb begin
        all_ones    = (dest == DEST_ALL_ONES);
        phys_hit    = ext ? (phys_id == dest)
                          : ((phys_id[7:0] == dest[7:0]) || (dest == LEGACY_BCAST));
        ext_log_hit = (dest[31:16] == log32[31:16]) && ((dest[15:0] & log32[15:0]) != 16'd0);
        flat_hit    = ((dest[7:0] & log8) != 8'd0);
        clus_hit    = ((dest[7:4] == CLUSTER_ANY) || (dest[7:4] == log8[7:4]))
                      && ((dest[3:0] & log8[3:0]) != 4'd0);
    end

    // Select the rule matching the request mode and target mode.
    always_comb begin
        if (!logical) begin
            hit = all_ones || phys_hit;
        end else if (ext) begin
            hit = all_ones || ext_log_hit;
        end else begin
            hit = cluster_model ? clus_hit : flat_hit;
        end
    end

endmodule

// File: rtl/irqd_shape.sv
// Module: irqd_shape
// Applies the shorthand override to the per-slot hits and removes
// slots that hold no controller. Assumes present is zero for padding.
module irqd_shape
    import irqd_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    localparam int SELF_W = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] hits,
    input  logic [NUM_SLOTS-1:0] present,
    input  logic [1:0]           shorthand,
    input  logic [SELF_W-1:0]    self_idx,
    output logic [NUM_SLOTS-1:0] mask
);

    logic [NUM_SLOTS-1:0] self_bit;
    logic [NUM_SLOTS-1:0] raw;

    // Build the one-hot sender bit.
    always_comb begin
        self_bit = '0;
        self_bit[self_idx] = 1'b1;
    end

    // Pick the set named by the shorthand code, then filter by presence.
    always_comb begin
        unique case (shorthand_e'(shorthand))
            SH_FIELD:  raw = hits;
            SH_SELF:   raw = self_bit;
            SH_ALL:    raw = '1;
            SH_OTHERS: raw = ~self_bit;
            default:   raw = '0;
        endcase
        mask = raw & present;
    end

endmodule

// File: rtl/irqd_lowest.sv
// Module: irqd_lowest
// Finds the lowest set bit of a vector and returns its index and a
// one-hot copy. Empty input gives found=0, index 0 and no bits.
module irqd_lowest #(
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec,
    output logic             found,
    output logic [IDX_W-1:0] idx,
    output logic [WIDTH-1:0] onehot
);

    // Scan from the top so the last assignment is the lowest index.
    always_comb begin
        found  = 1'b0;
        idx    = '0;
        onehot = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
        if (found) begin
            onehot[idx] = 1'b1;
        end
    end

endmodule

// File: rtl/irq_dest_decoder.sv
// Module: irq_dest_decoder
// Top of the destination decoder: one lane per target, shorthand and
// presence shaping, lowest-index pick, and a single output register.
// Assumes configuration inputs are stable while a request is sampled.
module irq_dest_decoder
    import irqd_pkg::*;
#(
    parameter int NUM_TGT = 8,
    localparam int NUM_SLOTS = round_to_word(NUM_TGT),
    localparam int SELF_W = $clog2(NUM_SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [31:0]             req_dest,
    input  logic                    req_logical,
    input  logic [1:0]              req_shorthand,
    input  logic                    req_lowpri,
    input  logic [SELF_W-1:0]       req_self,
    input  logic [NUM_TGT-1:0]      tgt_present,
    input  logic [NUM_TGT-1:0]      tgt_ext,
    input  logic [NUM_TGT*32-1:0]   tgt_phys_id,
    input  logic [NUM_TGT*8-1:0]    tgt_log8,
    input  logic [NUM_TGT-1:0]      tgt_cluster,
    input  logic [NUM_TGT*32-1:0]   tgt_log32,
    output logic                    out_valid,
    output logic [NUM_SLOTS-1:0]    out_mask,
    output logic                    out_pick_valid,
    output logic [SELF_W-1:0]       out_pick_idx
);

    logic [NUM_SLOTS-1:0] hits;
    logic [NUM_SLOTS-1:0] present_pad;
    logic [NUM_SLOTS-1:0] sel_mask;
    logic [NUM_SLOTS-1:0] pick_onehot;
    logic                 pick_found;
    logic [SELF_W-1:0]    pick_idx;

    // One matching lane per real target; padding slots never hit.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        if (g < NUM_TGT) begin : g_real
            irqd_lane u_lane (
                .dest          (req_dest),
                .logical       (req_logical),
                .ext           (tgt_ext[g]),
                .cluster_model (tgt_cluster[g]),
                .phys_id       (tgt_phys_id[g*32 +: 32]),
                .log8          (tgt_log8[g*8 +: 8]),
                .log32         (tgt_log32[g*32 +: 32]),
                .hit           (hits[g])
            );
            assign present_pad[g] = tgt_present[g];
        end else begin : g_pad
            assign hits[g]        = 1'b0;
            assign present_pad[g] = 1'b0;
        end
    end

    irqd_shape #(.NUM_SLOTS(NUM_SLOTS)) u_shape (
        .hits      (hits),
        .present   (present_pad),
        .shorthand (req_shorthand),
        .self_idx  (req_self),
        .mask      (sel_mask)
    );

    irqd_lowest #(.WIDTH(NUM_SLOTS)) u_pick (
        .vec    (sel_mask),
        .found  (pick_found),
        .idx    (pick_idx),
        .onehot (pick_onehot)
    );

    // Capture the decoded result for one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid      <= 1'b0;
            out_mask       <= '0;
            out_pick_valid <= 1'b0;
            out_pick_idx   <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_mask       <= req_lowpri ? pick_onehot : sel_mask;
                out_pick_valid <= pick_found;
                out_pick_idx   <= pick_idx;
            end
        end
    end

endmodule

// File: rtl/irqd_checker.sv
// Module: irqd_checker
// Property checks on the decoder's ports, attached by bind below.
// Assumes synchronous active-low reset.
module irqd_checker #(
    parameter int NUM_TGT = 8,
    localparam int NUM_SLOTS = ((NUM_TGT + 31) / 32) * 32,
    localparam int SELF_W = $clog2(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [1:0]           req_shorthand,
    input logic                 req_lowpri,
    input logic [SELF_W-1:0]    req_self,
    input logic [NUM_TGT-1:0]   tgt_present,
    input logic                 out_valid,
    input logic [NUM_SLOTS-1:0] out_mask,
    input logic                 out_pick_valid,
    input logic [SELF_W-1:0]    out_pick_idx
);

    logic [NUM_SLOTS-1:0] present_q;
    logic [SELF_W-1:0]    self_q;
    logic [1:0]           sh_q;
    logic                 lp_q;
    logic [NUM_SLOTS-1:0] self_bit_q;
    logic [NUM_SLOTS-1:0] below_pick;

    // Record the request context that produced the current output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present_q <= '0;
            self_q    <= '0;
            sh_q      <= '0;
            lp_q      <= 1'b0;
        end else if (req_valid) begin
            present_q <= NUM_SLOTS'(tgt_present);
            self_q    <= req_self;
            sh_q      <= req_shorthand;
            lp_q      <= req_lowpri;
        end
    end

    // Helper masks derived from recorded context and the pick output.
    always_comb begin
        self_bit_q = '0;
        self_bit_q[self_q] = 1'b1;
        below_pick = (NUM_SLOTS'(1) << out_pick_idx) - NUM_SLOTS'(1);
    end

    // R1
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    // R1
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(out_mask));
    // R9
    absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_mask & ~present_q) == '0));
    // R2
    self_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && sh_q == 2'd1) |-> ((out_mask & ~self_bit_q) == '0));
    // R2
    others_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && sh_q == 2'd3) |-> ((out_mask & self_bit_q) == '0));
    // R11
    lowpri_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && lp_q) |-> $onehot0(out_mask));
    // R10
    pick_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_pick_valid) |-> out_mask[out_pick_idx]);
    // R10
    pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_pick_valid) |-> ((out_mask & below_pick) == '0));
    // R10
    pick_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_pick_valid == (out_mask != '0)));

endmodule

bind irq_dest_decoder irqd_checker #(.NUM_TGT(NUM_TGT)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_shorthand  (req_shorthand),
    .req_lowpri     (req_lowpri),
    .req_self       (req_self),
    .tgt_present    (tgt_present),
    .out_valid      (out_valid),
    .out_mask       (out_mask),
    .out_pick_valid (out_pick_valid),
    .out_pick_idx   (out_pick_idx)
);

// File: tb/sim_irq_dest_decoder.sv
`timescale 1ns/1ps
// Bench: behavioural reference model, one request at a time, compared
// on the falling edge after each rising edge.
module sim_irq_dest_decoder;

    localparam int NT = 40;
    localparam int NS = 64;
    localparam int SW = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [31:0]       req_dest = '0;
    logic              req_logical = 1'b0;
    logic [1:0]        req_shorthand = '0;
    logic              req_lowpri = 1'b0;
    logic [SW-1:0]     req_self = '0;
    logic [NT-1:0]     tgt_present = '0;
    logic [NT-1:0]     tgt_ext = '0;
    logic [NT*32-1:0]  tgt_phys_id = '0;
    logic [NT*8-1:0]   tgt_log8 = '0;
    logic [NT-1:0]     tgt_cluster = '0;
    logic [NT*32-1:0]  tgt_log32 = '0;
    logic              out_valid;
    logic [NS-1:0]     out_mask;
    logic              out_pick_valid;
    logic [SW-1:0]     out_pick_idx;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    irq_dest_decoder #(.NUM_TGT(NT)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
        .req_logical(req_logical), .req_shorthand(req_shorthand),
        .req_lowpri(req_lowpri), .req_self(req_self),
        .tgt_present(tgt_present), .tgt_ext(tgt_ext), .tgt_phys_id(tgt_phys_id),
        .tgt_log8(tgt_log8), .tgt_cluster(tgt_cluster), .tgt_log32(tgt_log32),
        .out_valid(out_valid), .out_mask(out_mask),
        .out_pick_valid(out_pick_valid), .out_pick_idx(out_pick_idx)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference: does target t accept the current request field?
    function automatic bit accepts(int t);
        logic [31:0] d = req_dest;
        logic [31:0] pid = tgt_phys_id[t*32 +: 32];
        logic [7:0]  l8 = tgt_log8[t*8 +: 8];
        logic [31:0] l32 = tgt_log32[t*32 +: 32];
        if (!req_logical) begin
            if (d == 32'hFFFF_FFFF) return 1;
            if (tgt_ext[t]) return pid == d;
            return (pid[7:0] == d[7:0]) || (d == 32'hFF);
        end
        if (tgt_ext[t])
            return (d == 32'hFFFF_FFFF) ||
                   ((d[31:16] == l32[31:16]) && ((d[15:0] & l32[15:0]) != 0));
        if (tgt_cluster[t])
            return ((d[7:4] == 4'hF) || (d[7:4] == l8[7:4])) && ((d[3:0] & l8[3:0]) != 0);
        return (d[7:0] & l8) != 0;
    endfunction

    function automatic logic [NS-1:0] ref_set();
        logic [NS-1:0] m = '0;
        for (int t = 0; t < NT; t++) begin
            bit sel;
            case (req_shorthand)
                2'd0: sel = accepts(t);
                2'd1: sel = (t == int'(req_self));
                2'd2: sel = 1;
                default: sel = (t != int'(req_self));
            endcase
            m[t] = sel && tgt_present[t];
        end
        return m;
    endfunction

    task automatic send(input string tag, input logic [31:0] dest, input bit logical,
                        input logic [1:0] sh, input bit lowpri, input int self_i);
        logic [NS-1:0] m;
        logic [NS-1:0] exp_mask;
        bit pv;
        int pi;
        @(negedge clk);
        req_dest = dest; req_logical = logical; req_shorthand = sh;
        req_lowpri = lowpri; req_self = SW'(self_i); req_valid = 1'b1;
        m = ref_set();
        pv = 0; pi = 0;
        for (int i = NS - 1; i >= 0; i--) if (m[i]) begin pv = 1; pi = i; end
        exp_mask = m;
        if (lowpri) begin
            exp_mask = '0;
            if (pv) exp_mask[pi] = 1'b1;
        end
        @(negedge clk);
        check(tag, "valid", 64'(out_valid), 64'd1);
        check(tag, "mask", out_mask, exp_mask);
        check(tag, "pick", {out_pick_valid, 57'd0, out_pick_idx}, {pv, 57'd0, SW'(pi)});
        req_valid = 1'b0;
        req_dest = ~dest;
        @(negedge clk);
        // R1: idle cycle drops valid and holds the result
        check("R1", "idle valid", 64'(out_valid), 64'd0);
        check("R1", "idle hold", out_mask, exp_mask);
    endtask

    task automatic base_config();
        for (int i = 0; i < NT; i++) begin
            tgt_present[i] = !(i == 5 || i == 30);
            tgt_ext[i] = (i >= 32) || (i == 3);
            tgt_phys_id[i*32 +: 32] = tgt_ext[i] ? 32'h0001_0000 + i : 32'(i + 16);
            tgt_cluster[i] = (i >= 16 && i < 32);
            tgt_log8[i*8 +: 8] = tgt_cluster[i] ? {4'((i - 16) / 4), 4'(1 << (i % 4))}
                                                : 8'(1 << (i % 8));
            tgt_log32[i*32 +: 32] = {16'(i / 8), 16'(1 << (i % 16))};
        end
        tgt_phys_id[7*32 +: 32] = 32'hFF;
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        base_config();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        check("R12", "reset valid", 64'(out_valid), 64'd0);
        check("R12", "reset mask", out_mask, 64'd0);
        check("R12", "reset pick", {out_pick_valid, 57'd0, out_pick_idx}, 64'd0);
        rst_n = 1'b1;

        send("R2", 32'h0, 0, 2'd1, 0, 9);
        send("R2", 32'h0, 0, 2'd2, 0, 0);
        send("R2", 32'h0, 0, 2'd3, 0, 0);
        send("R2", 32'h0, 1, 2'd3, 0, 5);
        send("R2", 32'h0, 0, 2'd1, 0, 5);
        send("R3", 32'hFFFF_FFFF, 0, 2'd0, 0, 0);
        send("R4", 32'h0000_0019, 0, 2'd0, 0, 0);
        send("R4", 32'h0001_0021, 0, 2'd0, 0, 0);
        send("R4", 32'h0000_00FF, 0, 2'd0, 0, 0);
        send("R4", 32'h0000_01FF, 0, 2'd0, 0, 0);
        send("R5", 32'hFFFF_FFFF, 1, 2'd0, 0, 0);
        send("R6", 32'h0004_0003, 1, 2'd0, 0, 0);
        send("R6", 32'h0003_0003, 1, 2'd0, 0, 0);
        send("R7", 32'h0000_0003, 1, 2'd0, 0, 0);
        send("R8", 32'h0000_0021, 1, 2'd0, 0, 0);
        send("R8", 32'h0000_00F3, 1, 2'd0, 0, 0);
        send("R9", 32'hFFFF_FFFF, 0, 2'd0, 0, 0);
        send("R10", 32'h00AB_CDEF, 0, 2'd0, 0, 0);
        send("R11", 32'h0, 0, 2'd2, 1, 0);
        send("R11", 32'h0, 0, 2'd3, 1, 0);
        send("R11", 32'h00AB_CDEF, 0, 2'd0, 1, 0);

        for (int n = 0; n < 400; n++) begin
            logic [31:0] d;
            bit lg;
            logic [1:0] sh;
            if (n % 20 == 0) begin
                for (int i = 0; i < NT; i++) begin
                    tgt_present[i] = ($urandom % 5) != 0;
                    tgt_ext[i] = $urandom % 2;
                    tgt_cluster[i] = $urandom % 2;
                    tgt_phys_id[i*32 +: 32] = ($urandom % 2) ? 32'($urandom % 64) : $urandom;
                    tgt_log8[i*8 +: 8] = 8'($urandom);
                    tgt_log32[i*32 +: 32] = {16'($urandom % 4), 16'($urandom)};
                end
            end
            case ($urandom % 6)
                0: d = 32'hFFFF_FFFF;
                1: d = 32'hFF;
                2: d = 32'($urandom % 64);
                3: d = {16'($urandom % 4), 16'($urandom)};
                default: d = 32'($urandom % 256);
            endcase
            lg = $urandom % 2;
            sh = (($urandom % 4) == 0) ? 2'($urandom) : 2'd0;
            send(sh != 0 ? "R2" : (lg ? "R6" : "R4"), d, lg, sh, ($urandom % 4) == 0,
                 int'($urandom % NS));
        end
        finished = 1;
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

endmodule